// File: doc/BRIEF.md
# Mode-Selected Bit-Slice ALU

This block is a combinational arithmetic/logic unit built from a chain of identical one-bit slices. Each slice takes one bit of each operand, a carry from the slice below, and the shared controls, and produces one result bit and a carry to the slice above. The default build chains eight slices. The result is one bit wider than the operands, and its top bit is the final carry-out.

One mode input chooses between bitwise logic and arithmetic. A two-bit operation select then picks the function. In logic mode the unit can pass the first operand through, invert it, or combine it with the second operand by XOR or XNOR. In arithmetic mode the first operand is optionally inverted, the second operand is either added or dropped, and the external carry-in supplies an optional +1. With inversion, addition and carry-in all active, the result is the second operand minus the first.

The block has no clock and no state. Its outputs settle once the carry has rippled through every slice.

Top module: `alu_mode_top`

## Requirements
- R1: With `arith_mode`=0, `op_sel` values 0, 1, 2 and 3 give `result[7:0]` equal to `opa`, bitwise NOT `opa`, `opa` XOR `opb` and `opa` XNOR `opb` respectively.
- R2: With `arith_mode`=0, `carry_in` has no effect on any bit of `result`.
- R3: With `arith_mode`=0, `result[8]` is 0 for every operation.
- R4: With `arith_mode`=1 and `op_sel`=0, `result` equals the 9-bit unsigned sum `opa` + `carry_in`.
- R5: With `arith_mode`=1 and `op_sel`=1, `result` equals the 9-bit unsigned sum (255 - `opa`) + `carry_in`.
- R6: With `arith_mode`=1 and `op_sel`=2, `result` equals the 9-bit unsigned sum `opa` + `opb` + `carry_in`.
- R7: With `arith_mode`=1 and `op_sel`=3, `result` equals the 9-bit unsigned sum (255 - `opa`) + `opb` + `carry_in`; with `carry_in`=1, `result[7:0]` equals `opb` - `opa` modulo 256.
- R8: In arithmetic mode, `result[8]` is the carry out of the top slice, which is bit 8 of the unsigned sums defined in R4 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| carry_in | input | 1 | Carry into the lowest slice |
| arith_mode | input | 1 | 0 selects bitwise logic, 1 selects arithmetic |
| op_sel | input | 2 | Operation select within the chosen mode |
| result | output | 9 | Result; bit 8 is the final carry-out |

## Verification
The bound checker evaluates the full 9-bit result against an arithmetic formula for every arithmetic select. It also checks that the top bit stays low in logic mode, and it does this every time an input changes. The bench covers every pair of operands for every mode, select and carry-in value. Only that sweep shows that the carry-in is ignored in logic mode, by comparing the same operand pair under both carry values. The sweep also exercises the full ripple through every slice, for example 255 plus 1 and the wrap of B minus A.

// File: rtl/alu_mode_pkg.sv
package alu_mode_pkg;

  // Operation select codes, shared by both modes
  typedef enum logic [1:0] {
    SEL_PASS  = 2'd0,
    SEL_INV   = 2'd1,
    SEL_MIX   = 2'd2,
    SEL_INVMX = 2'd3
  } op_sel_e;

  // Per-slice control decoded once for the whole chain
  typedef struct packed {
    logic invert_a;   // first operand term is inverted
    logic use_b;      // second operand contributes
    logic carry_en;   // slice propagates and uses carries
  } slice_ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_mode_pkg::*;
(
  input  logic        arith_mode,
  input  logic [1:0]  op_sel,
  output slice_ctrl_t ctrl
);

  always_comb begin
    ctrl.invert_a = op_sel[0];
    ctrl.use_b    = op_sel[1];
    ctrl.carry_en = arith_mode;
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_mode_pkg::*;
(
  input  logic        a_bit,
  input  logic        b_bit,
  input  logic        c_in,
  input  slice_ctrl_t ctrl,
  output logic        f_bit,
  output logic        c_out
);

  logic a_term;
  logic b_term;
  logic c_term;

  always_comb begin
    a_term = a_bit ^ ctrl.invert_a;
    b_term = b_bit & ctrl.use_b;
    c_term = c_in & ctrl.carry_en;
    f_bit  = a_term ^ b_term ^ c_term;
    c_out  = ctrl.carry_en &
             ((a_term & b_term) | (a_term & c_in) | (b_term & c_in));
  end

endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
  import alu_mode_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_vec,
  input  logic [WIDTH-1:0] b_vec,
  input  logic             c_first,
  input  slice_ctrl_t      ctrl,
  output logic [WIDTH-1:0] f_vec,
  output logic             c_last
);

  localparam int NCARRY = WIDTH + 1;

  logic [NCARRY-1:0] carry;

  assign carry[0] = c_first;

  for (genvar g = 0; g < WIDTH; g++) begin : g_slice
    alu_bit_slice u_slice (
      .a_bit (a_vec[g]),
      .b_bit (b_vec[g]),
      .c_in  (carry[g]),
      .ctrl  (ctrl),
      .f_bit (f_vec[g]),
      .c_out (carry[g+1])
    );
  end

  assign c_last = carry[NCARRY-1];

endmodule

// File: rtl/alu_mode_top.sv
module alu_mode_top
  import alu_mode_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             carry_in,
  input  logic             arith_mode,
  input  logic [1:0]       op_sel,
  output logic [WIDTH:0]   result
);

  slice_ctrl_t      ctrl;
  logic [WIDTH-1:0] f_low;
  logic             c_top;

  alu_op_decode u_decode (
    .arith_mode (arith_mode),
    .op_sel     (op_sel),
    .ctrl       (ctrl)
  );

  alu_slice_chain #(.WIDTH(WIDTH)) u_chain (
    .a_vec   (opa),
    .b_vec   (opb),
    .c_first (carry_in),
    .ctrl    (ctrl),
    .f_vec   (f_low),
    .c_last  (c_top)
  );

  assign result = {c_top, f_low};

endmodule

// File: rtl/alu_mode_checker.sv
module alu_mode_checker #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             carry_in,
  input logic             arith_mode,
  input logic [1:0]       op_sel,
  input logic [WIDTH:0]   result
);

  localparam int RW = WIDTH + 1;

  logic [RW-1:0] ext_a;
  logic [RW-1:0] ext_na;
  logic [RW-1:0] ext_b;
  logic [RW-1:0] ext_c;

  always_comb begin
    ext_a  = {1'b0, opa};
    ext_na = {1'b0, ~opa};
    ext_b  = {1'b0, opb};
    ext_c  = {{WIDTH{1'b0}}, carry_in};
  end

  always_comb begin
    if (!arith_mode)
      assert_logic_top_zero_R3: assert (result[WIDTH] == 1'b0);
    if (arith_mode && op_sel == 2'd0)
      assert_inc_sum_R4: assert (result == ext_a + ext_c);
    if (arith_mode && op_sel == 2'd1)
      assert_inv_inc_sum_R5: assert (result == ext_na + ext_c);
    if (arith_mode && op_sel == 2'd2)
      assert_add_sum_R6: assert (result == ext_a + ext_b + ext_c);
    if (arith_mode && op_sel == 2'd3)
      assert_sub_sum_R7: assert (result == ext_na + ext_b + ext_c);
  end

endmodule

bind alu_mode_top alu_mode_checker #(.WIDTH(WIDTH)) u_checker (
  .opa        (opa),
  .opb        (opb),
  .carry_in   (carry_in),
  .arith_mode (arith_mode),
  .op_sel     (op_sel),
  .result     (result)
);

// File: tb/test_alu_mode_top.sv
`timescale 1ns/1ps
module test_alu_mode_top;

  logic       clk = 1'b0;
  logic [7:0] opa = '0;
  logic [7:0] opb = '0;
  logic       carry_in = 1'b0;
  logic       arith_mode = 1'b0;
  logic [1:0] op_sel = '0;
  logic [8:0] result;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  alu_mode_top #(.WIDTH(8)) i_alu_mode_top (
    .opa        (opa),
    .opb        (opb),
    .carry_in   (carry_in),
    .arith_mode (arith_mode),
    .op_sel     (op_sel),
    .result     (result)
  );

  function automatic int model(int m, int s, int c, int a, int b);
    int ra;
    int rb;
    if (m == 0) begin
      case (s)
        0: return a;
        1: return 255 - a;
        2: return a ^ b;
        default: return 255 - (a ^ b);
      endcase
    end
    ra = (s % 2 == 1) ? 255 - a : a;
    rb = (s >= 2) ? b : 0;
    return (ra + rb + c) % 512;
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (m=%0d s=%0d c=%0d a=%0d b=%0d)",
               tag, got, exp, arith_mode, op_sel, carry_in, opa, opb);
    end
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int logic_c0;
    #2;
    // Idle state: all inputs low gives a zero result (R1 pass-through of 0)
    check("R1 idle", int'(result), 0);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int a = 0; a < 256; a++) begin
          for (int b = 0; b < 256; b++) begin
            arith_mode = m[0];
            op_sel     = s[1:0];
            opa        = a[7:0];
            opb        = b[7:0];
            carry_in   = 1'b0;
            #1;
            logic_c0 = int'(result);
            if (m == 0) begin
              check("R1 logic", logic_c0, model(0, s, 0, a, b));
              check("R3 logic top bit", int'(result[8]), 0);
            end else begin
              case (s)
                0: check("R4 pass+cin", logic_c0, model(1, s, 0, a, b));
                1: check("R5 inv+cin", logic_c0, model(1, s, 0, a, b));
                2: check("R6 add", logic_c0, model(1, s, 0, a, b));
                default: check("R7 inv add", logic_c0, model(1, s, 0, a, b));
              endcase
              check("R8 carry-out", int'(result[8]), model(1, s, 0, a, b) / 256);
            end
            carry_in = 1'b1;
            #1;
            if (m == 0) begin
              check("R2 carry ignored", int'(result), logic_c0);
            end else begin
              case (s)
                0: check("R4 increment", int'(result), model(1, s, 1, a, b));
                1: check("R5 negate", int'(result), model(1, s, 1, a, b));
                2: check("R6 add+1", int'(result), model(1, s, 1, a, b));
                default: begin
                  check("R7 inv add+1", int'(result), model(1, s, 1, a, b));
                  check("R7 b minus a", int'(result[7:0]), (b - a + 256) % 256);
                end
              endcase
              check("R8 carry-out", int'(result[8]), model(1, s, 1, a, b) / 256);
            end
          end
        end
      end
    end

    // Named corners: full ripple and wrap
    arith_mode = 1'b1; op_sel = 2'd0; opa = 8'hFF; opb = 8'h00; carry_in = 1'b1;
    #1 check("R8 ripple 255+1", int'(result), 256);
    op_sel = 2'd3; opa = 8'h01; opb = 8'h00; carry_in = 1'b1;
    #1 check("R7 0-1 wrap", int'(result[7:0]), 255);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule